// File: doc/BRIEF.md
# Byte-Lane Synchronous SRAM with Flow-Through Read

This block is a single-port synchronous RAM organised as four byte lanes. Each lane is nine bits wide: eight data bits and one parity bit. One rising clock edge registers the word address, the write data, three chip-select inputs and the write controls. What happens in the clock period that follows depends on the cycle type captured at that edge.

In a read cycle, the stored word at the registered address reaches the output through combinational logic only, with no output register. In a write cycle, the registered data goes into the enabled lanes. The commit happens at the edge that closes the cycle, so a read captured at that same edge already sees the new contents.

The data output is driven only when the cycle is a read and the asynchronous active-low output enable is low. Otherwise the block releases the output. The pad ring, which is outside this block, turns the release indication into high impedance.

The control path is a three-state machine. The state register is loaded at every edge:
- `CYC_IDLE` is loaded when the device is not selected.
- `CYC_WRITE` is loaded when the device is selected and either write input is low.
- `CYC_READ` is loaded when the device is selected and neither write input is low.

Every state can go to every other state at any edge. The named transitions are select-drop (to idle), write-start (to write) and read-start (to read). Reset forces `CYC_IDLE`. Burst address sequencing is done by a neighbouring block.

Top module: `bytelane_ft_sram`

## Requirements
- R1: Address, data, selects and write controls are registered on the rising clock edge. Changing `addr` between edges does not change `rd_q` during a read cycle.
- R2: The device is selected only when `sel_a_n`=0, `sel_b_n`=0 and `sel_c`=1. Only then does a write change the array.
- R3: A cycle captured with the device not selected writes nothing and leaves the output released (`rd_oe`=0, `rd_q`=0).
- R4: A selected cycle with `wr_all_n`=0 writes all four lanes, whatever the values of `lane_wr_n` and `lane_en_n`.
- R5: When `wr_all_n`=1 and `lane_wr_n`=0, lane i is written only if `lane_en_n[i]`=0. Lane i occupies bits [9i+8:9i] of `wdata` and `rd_q`, and bit 9i+8 is that lane's parity bit, which is written together with its byte. A lane whose enable is high keeps its contents.
- R6: A selected cycle with `wr_all_n`=1 and `lane_wr_n`=1 is a read, whatever `lane_en_n` and `wdata` are. It leaves the array unchanged.
- R7: `out_en_n` acts without a clock edge. While it is high, the output is released (`rd_oe`=0, `rd_q`=0). While it is low in a read cycle, the data is driven.
- R8: Read data is flow-through: it is valid in the cycle that follows the capturing edge. A read captured right after a write to the same address returns the newly written word.
- R9: During a write cycle the output is released (`rd_oe`=0, `rd_q`=0).
- R10: While reset is asserted, and in the first cycle after it with the device not selected, the output is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all registered inputs |
| rst_n | input | 1 | Active-low asynchronous reset of the control state |
| addr | input | AW (4) | Word address |
| wdata | input | 9*LANES (36) | Write data; lane i at [9i+8:9i], parity at bit 9i+8 |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b_n | input | 1 | Second chip select, active low |
| sel_c | input | 1 | Third chip select, active high |
| wr_all_n | input | 1 | Global write, active low, writes every lane |
| lane_wr_n | input | 1 | Active-low qualifier for the per-lane enables |
| lane_en_n | input | LANES (4) | Active-low per-lane write enables |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| rd_q | output | 9*LANES (36) | Read data, zero while released |
| rd_oe | output | 1 | High while `rd_q` is driven; low means high impedance at the pad |

## Verification
The bench builds the block with its defaults: four lanes and a 4-bit address, which gives 16 words. At that size every word can be written and read back. All 16 combinations of lane enables can be applied to one word, and all 8 combinations of the three selects can be tried, both for writes and for reads. The bench predicts every result from a word-level model that merges lanes arithmetically. Read-after-write to the same address, address changes in mid-cycle, and output-enable toggles in mid-cycle are each placed at the sample point where the flow-through path must already show the new value.

// File: rtl/ftsram_pkg.sv
package ftsram_pkg;
    // one lane: eight data bits plus parity in the top bit
    localparam int LANE_BITS = 9;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_e;
endpackage

// File: rtl/ftsram_cycle_ctrl.sv
module ftsram_cycle_ctrl
    import ftsram_pkg::*;
#(
    parameter int AW    = 4,
    parameter int LANES = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [AW-1:0]              addr,
    input  logic [LANES*LANE_BITS-1:0] wdata,
    input  logic                       sel_a_n,
    input  logic                       sel_b_n,
    input  logic                       sel_c,
    input  logic                       wr_all_n,
    input  logic                       lane_wr_n,
    input  logic [LANES-1:0]           lane_en_n,
    output cyc_e                       cyc_q,
    output logic [AW-1:0]              addr_q,
    output logic [LANES*LANE_BITS-1:0] wdata_q,
    output logic [LANES-1:0]           wr_mask,
    output logic                       rd_cyc
);
    localparam int W = LANES * LANE_BITS;

    logic             sel_now;
    logic             wr_req;
    cyc_e             cyc_d;
    logic [LANES-1:0] mask_d;
    logic [LANES-1:0] mask_q;
    logic             live_q;

    assign sel_now = !sel_a_n && !sel_b_n && sel_c;
    assign wr_req  = !wr_all_n || !lane_wr_n;

    // next cycle type: select-drop, write-start, read-start
    always_comb begin
        if (!sel_now)
            cyc_d = CYC_IDLE;
        else if (wr_req)
            cyc_d = CYC_WRITE;
        else
            cyc_d = CYC_READ;
    end

    // lanes to commit; the global write overrides the lane enables
    always_comb begin
        if (!wr_all_n)
            mask_d = {LANES{1'b1}};
        else if (!lane_wr_n)
            mask_d = ~lane_en_n;
        else
            mask_d = '0;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q  <= CYC_IDLE;
            live_q <= 1'b0;
        end else begin
            cyc_q  <= cyc_d;
            live_q <= 1'b1;
        end
    end

    // captured address, data and lane mask
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
        end else begin
            addr_q  <= addr;
            wdata_q <= wdata;
            mask_q  <= mask_d;
        end
    end

    // outputs per state
    always_comb begin
        wr_mask = '0;
        rd_cyc  = 1'b0;
        unique case (cyc_q)
            CYC_IDLE:  begin end
            CYC_READ:  rd_cyc  = 1'b1;
            CYC_WRITE: wr_mask = mask_q;
            default:   begin end
        endcase
    end

    // R3
    desel_no_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !$past(sel_now)) |-> (wr_mask == '0 && !rd_cyc));

    // R4
    all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(sel_now) && !$past(wr_all_n)) |-> (wr_mask == {LANES{1'b1}}));

    // R5
    lane_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(sel_now) && $past(wr_all_n) && !$past(lane_wr_n))
            |-> (wr_mask == ~$past(lane_en_n)));

    // R6
    read_cyc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(sel_now) && $past(wr_all_n) && $past(lane_wr_n))
            |-> (rd_cyc && wr_mask == '0));

    logic unused_w;
    assign unused_w = ^wdata_q[W-1:0] & 1'b0;
endmodule

// File: rtl/ftsram_lane_store.sv
module ftsram_lane_store #(
    parameter int AW   = 4,
    parameter int BITS = 9
) (
    input  logic            clk,
    input  logic            we,
    input  logic [AW-1:0]   addr,
    input  logic [BITS-1:0] wdata,
    output logic [BITS-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [BITS-1:0] mem [DEPTH];

    // commit at the edge closing the write cycle
    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wdata;
    end

    // flow-through read
    assign rdata = mem[addr];
endmodule

// File: rtl/ftsram_out_drv.sv
module ftsram_out_drv #(
    parameter int W = 36
) (
    input  logic         rd_cyc,
    input  logic         out_en_n,
    input  logic [W-1:0] rdata,
    output logic         drv_en,
    output logic [W-1:0] q
);
    assign drv_en = rd_cyc && !out_en_n;
    assign q      = drv_en ? rdata : '0;
endmodule

// File: rtl/bytelane_ft_sram.sv
module bytelane_ft_sram
    import ftsram_pkg::*;
#(
    parameter int AW    = 4,
    parameter int LANES = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [AW-1:0]              addr,
    input  logic [LANES*LANE_BITS-1:0] wdata,
    input  logic                       sel_a_n,
    input  logic                       sel_b_n,
    input  logic                       sel_c,
    input  logic                       wr_all_n,
    input  logic                       lane_wr_n,
    input  logic [LANES-1:0]           lane_en_n,
    input  logic                       out_en_n,
    output logic [LANES*LANE_BITS-1:0] rd_q,
    output logic                       rd_oe
);
    localparam int W = LANES * LANE_BITS;

    cyc_e             ctl_cyc;
    logic [AW-1:0]    ctl_addr;
    logic [W-1:0]     ctl_wdata;
    logic [LANES-1:0] ctl_mask;
    logic             ctl_rd;
    logic [W-1:0]     bank_q;
    logic             drv_en;

    ftsram_cycle_ctrl #(.AW(AW), .LANES(LANES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .wdata     (wdata),
        .sel_a_n   (sel_a_n),
        .sel_b_n   (sel_b_n),
        .sel_c     (sel_c),
        .wr_all_n  (wr_all_n),
        .lane_wr_n (lane_wr_n),
        .lane_en_n (lane_en_n),
        .cyc_q     (ctl_cyc),
        .addr_q    (ctl_addr),
        .wdata_q   (ctl_wdata),
        .wr_mask   (ctl_mask),
        .rd_cyc    (ctl_rd)
    );

    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        ftsram_lane_store #(.AW(AW), .BITS(LANE_BITS)) u_store (
            .clk   (clk),
            .we    (ctl_mask[gi]),
            .addr  (ctl_addr),
            .wdata (ctl_wdata[gi*LANE_BITS +: LANE_BITS]),
            .rdata (bank_q[gi*LANE_BITS +: LANE_BITS])
        );
    end

    ftsram_out_drv #(.W(W)) u_out (
        .rd_cyc   (ctl_rd),
        .out_en_n (out_en_n),
        .rdata    (bank_q),
        .drv_en   (drv_en),
        .q        (rd_q)
    );

    assign rd_oe = drv_en;

    // R9
    wr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_cyc == CYC_WRITE) |-> !drv_en);

    // R8
    flow_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en |-> (rd_q == bank_q));
endmodule

// File: tb/test_bytelane_ft_sram.sv
module test_bytelane_ft_sram;
    localparam int CLK_PERIOD = 10;
    localparam int AW    = 4;
    localparam int LANES = 4;
    localparam int W     = LANES * 9;
    localparam int DEPTH = 1 << AW;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [AW-1:0]    addr;
    logic [W-1:0]     wdata;
    logic             sel_a_n, sel_b_n, sel_c;
    logic             wr_all_n, lane_wr_n;
    logic [LANES-1:0] lane_en_n;
    logic             out_en_n;
    logic [W-1:0]     rd_q;
    logic             rd_oe;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    logic [W-1:0] model [DEPTH];

    bytelane_ft_sram #(.AW(AW), .LANES(LANES)) i_bytelane_ft_sram (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .sel_c(sel_c),
        .wr_all_n(wr_all_n), .lane_wr_n(lane_wr_n), .lane_en_n(lane_en_n),
        .out_en_n(out_en_n), .rd_q(rd_q), .rd_oe(rd_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // released output: rd_oe low and rd_q zero
    task automatic chk_rel(input string req);
        chk(req, {rd_q, rd_oe} == {{W{1'b0}}, 1'b0} ? W'(0) : W'(1), W'(0));
    endtask

    task automatic chk_rd(input string req, input int a);
        chk({req, " oe"}, W'(rd_oe), W'(1));
        chk(req, rd_q, model[a]);
    endtask

    function automatic logic [W-1:0] pat(input int a, input int salt);
        logic [W-1:0] v;
        for (int i = 0; i < LANES; i++)
            v[i*9 +: 9] = 9'((a + 1) * (7 + 6 * i) + salt * 37 + i * 101);
        return v;
    endfunction

    // sel = {sel_a_n, sel_b_n, sel_c}; selected is 3'b001
    task automatic cyc(input logic [2:0] sel, input logic gw_n, input logic bw_n,
                       input logic [LANES-1:0] len_n, input int a, input logic [W-1:0] d);
        @(negedge clk);
        {sel_a_n, sel_b_n, sel_c} = sel;
        wr_all_n  = gw_n;
        lane_wr_n = bw_n;
        lane_en_n = len_n;
        addr      = AW'(a);
        wdata     = d;
        @(posedge clk);
        #3;
        if (sel == 3'b001 && (!gw_n || !bw_n))
            for (int i = 0; i < LANES; i++)
                if (!gw_n || !len_n[i])
                    model[a][i*9 +: 9] = d[i*9 +: 9];
    endtask

    task automatic rd(input int a);
        cyc(3'b001, 1'b1, 1'b1, '1, a, '0);
    endtask

    task automatic summary;
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; addr = '0; wdata = '0;
        {sel_a_n, sel_b_n, sel_c} = 3'b110;
        wr_all_n = 1'b1; lane_wr_n = 1'b1; lane_en_n = '1; out_en_n = 1'b0;
        repeat (3) @(posedge clk);
        #3;
        chk_rel("R10 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #3;
        chk_rel("R10 after reset");

        // R4: global write fills every word; lane controls must not matter
        for (int a = 0; a < DEPTH; a++) begin
            cyc(3'b001, 1'b0, a[0], 4'b1010, a, pat(a, 1));
            chk_rel("R9 write cycle");
        end
        for (int a = 0; a < DEPTH; a++) begin
            rd(a);
            chk_rd("R4 R6 readback", a);
        end

        // R8: read right after write to the same word
        cyc(3'b001, 1'b0, 1'b1, '1, 3, pat(3, 2));
        rd(3);
        chk_rd("R8 read after write", 3);

        // R1: address moves in mid-cycle
        rd(6);
        @(negedge clk);
        addr = AW'(9);
        #1;
        chk_rd("R1 addr held", 6);

        // R7: output enable without a clock edge
        out_en_n = 1'b1;
        #1;
        chk_rel("R7 disabled");
        out_en_n = 1'b0;
        #1;
        chk_rd("R7 enabled", 6);

        // R5: every lane-enable pattern
        for (int m = 0; m < 16; m++) begin
            cyc(3'b001, 1'b1, 1'b0, ~4'(m), 5, pat(m, 3));
            chk_rel("R9 lane write");
            rd(5);
            chk_rd("R5 lane merge", 5);
        end

        // R6: lane enables without the qualifier are a read
        cyc(3'b001, 1'b1, 1'b1, 4'h0, 5, '1);
        chk_rd("R6 read cycle", 5);
        rd(5);
        chk_rd("R6 no write", 5);

        // R2 R3: all select combinations
        for (int c = 0; c < 8; c++) begin
            cyc(3'(c), 1'b0, 1'b1, '1, 7, pat(c, 4));
            if (c != 1) chk_rel("R3 deselected write");
            rd(7);
            chk_rd("R2 select decode", 7);
            if (c != 1) begin
                cyc(3'(c), 1'b1, 1'b1, '1, 7, '0);
                chk_rel("R3 deselected read");
            end
        end

        done = 1;
        summary();
        $finish;
    end
endmodule